// File: doc/BRIEF.md
# MII Receive Frame Error Classifier

This block sits beside a 4-bit MII receive path and sorts every received frame into error classes for a bank of statistics counters. It waits for the start-of-frame delimiter nibble, then pairs the nibbles that follow into octets, with the low nibble first. It runs a CRC-32 over every whole octet, counts the octets and remembers any receive-error strobe or FIFO overflow seen during the frame. When receive data valid drops, it raises one-cycle event pulses, one line per error class. A counter bank increments on each pulse.

The controller has three states. `ST_IDLE` waits for a frame. `ST_PRE` consumes preamble nibbles. `ST_BODY` collects the frame. The transitions are:
- IDLE→PRE: data valid and carrier sense are both high and the nibble is not the delimiter.
- IDLE→BODY or PRE→BODY: the delimiter nibble 0xD arrives. This is the frame start, which clears all per-frame state.
- PRE→IDLE: data valid drops before any delimiter. This is silent and raises no events.
- BODY→IDLE: data valid drops. This is the frame end, which registers the event pulses.

An error on the CRC is split by the parity of the nibble count. An even count gives a check-sequence error. An odd count means a dribble nibble, so the failure is reported as an alignment error.

Top module: `mii_rx_err_classifier`

## Requirements
- R1: A frame starts only on the nibble 0xD. Every nibble after that delimiter, up to the fall of data valid, belongs to the frame, and nibbles are paired into octets with the first nibble as bits 3:0. A frame whose whole octets carry a correct CRC-32 (reflected, initialised to all ones, residue 0xDEBB20E3) raises no event.
- R2: Event outputs are high only in the single cycle after data valid falls at the end of a frame. They are low in every other cycle.
- R3: A frame with a bad CRC and an even nibble count pulses `ev_fcs_err`.
- R4: A frame with a bad CRC and an odd nibble count pulses `ev_align_err` and not `ev_fcs_err`. A trailing odd nibble on a frame with a good CRC raises no event.
- R5: `rx_er` high for one or more body cycles while data valid is high pulses `ev_symbol_err` exactly once for that frame.
- R6: A frame of more than MAX_OCTETS octets (default 1518, FCS included) pulses `ev_too_long`. A frame of exactly MAX_OCTETS octets does not.
- R7: `fifo_ovf` high in any body cycle pulses `ev_missed`.
- R8: `ev_errored` pulses for every frame that raises any of the other five events, and only then.
- R9: Data valid without carrier sense at the start, or a burst that ends before any delimiter, raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive nibble clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error strobe |
| crs | input | 1 | Carrier sense |
| rxd | input | 4 | Receive nibble |
| fifo_ovf | input | 1 | Receive FIFO overflow indication |
| ev_errored | output | 1 | Pulse: frame had any error |
| ev_fcs_err | output | 1 | Pulse: bad CRC, even nibble count |
| ev_align_err | output | 1 | Pulse: bad CRC, odd nibble count |
| ev_symbol_err | output | 1 | Pulse: receive error during frame |
| ev_too_long | output | 1 | Pulse: frame longer than MAX_OCTETS |
| ev_missed | output | 1 | Pulse: frame lost to FIFO overflow |

## Verification
The bench targets the parity split. A design that counted nibbles wrongly would report dribble frames as check-sequence errors, or would flag good frames that carry a trailing nibble. Length is probed at exactly 1518 and at 1519 octets, where an off-by-one counter would miss the long frame or flag a legal one. Receive-error and overflow strobes are placed on the first and the last body nibble, and random frames mix all error types. A design that cleared its sticky flags at the wrong time, pulsed for more than one cycle, or reacted to preamble-only or carrier-less bursts would raise events the bench does not expect.

// File: rtl/mii_rxc_pkg.sv
package mii_rxc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_BODY = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic errored;
        logic fcs;
        logic align;
        logic symbol;
        logic too_long;
        logic missed;
    } rx_events_t;

    localparam logic [3:0]  SFD_NIBBLE = 4'hD;
    localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
    localparam logic [31:0] CRC_GOOD   = 32'hDEBB20E3;
endpackage

// File: rtl/mii_nibble_pair.sv
module mii_nibble_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       nib_valid,
    input  logic [3:0] nib,
    output logic       octet_vld,
    output logic [7:0] octet,
    output logic       odd
);
    logic [3:0] lo_q;
    logic       half_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            half_q <= 1'b0;
        end else if (clear) begin
            half_q <= 1'b0;
        end else if (nib_valid) begin
            if (!half_q) lo_q <= nib;
            half_q <= ~half_q;
        end
    end

    assign octet_vld = nib_valid && half_q && !clear;
    assign octet     = {nib, lo_q};
    assign odd       = half_q;

    // R1: every accepted nibble flips the pairing phase
    a_r1_phase_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_valid && !clear) |=> (half_q != $past(half_q)));
endmodule

// File: rtl/mii_crc32_acc.sv
module mii_crc32_acc
    import mii_rxc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc_q
);
    function automatic logic [31:0] step8(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '1;
        else if (init) crc_q <= '1;
        else if (en)   crc_q <= step8(crc_q, data);
    end

    // R1: a new frame starts the check from all ones
    a_r1_crc_seeded: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc_q == 32'hFFFF_FFFF));
endmodule

// File: rtl/mii_rx_err_classifier.sv
module mii_rx_err_classifier
    import mii_rxc_pkg::*;
#(
    parameter int MAX_OCTETS = 1518
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_dv,
    input  logic       rx_er,
    input  logic       crs,
    input  logic [3:0] rxd,
    input  logic       fifo_ovf,
    output logic       ev_errored,
    output logic       ev_fcs_err,
    output logic       ev_align_err,
    output logic       ev_symbol_err,
    output logic       ev_too_long,
    output logic       ev_missed
);
    localparam int OCT_LIMIT = MAX_OCTETS + 1;
    localparam int OCT_W     = $clog2(OCT_LIMIT + 1);

    rx_state_e  state_q, state_d;
    logic       frame_start, frame_end, body_nib;
    logic       octet_vld, odd;
    logic [7:0] octet;
    logic [31:0] crc_q;
    logic [OCT_W-1:0] oct_cnt_q;
    logic       sym_seen_q, ovf_seen_q;
    rx_events_t ev_d, ev_q;

    always_comb begin
        state_d     = state_q;
        frame_start = 1'b0;
        frame_end   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_dv && crs) begin
                    if (rxd == SFD_NIBBLE) begin
                        state_d     = ST_BODY;
                        frame_start = 1'b1;
                    end else begin
                        state_d = ST_PRE;
                    end
                end
            end
            ST_PRE: begin
                if (!rx_dv) begin
                    state_d = ST_IDLE;
                end else if (rxd == SFD_NIBBLE) begin
                    state_d     = ST_BODY;
                    frame_start = 1'b1;
                end
            end
            ST_BODY: begin
                if (!rx_dv) begin
                    state_d   = ST_IDLE;
                    frame_end = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign body_nib = (state_q == ST_BODY) && rx_dv;

    mii_nibble_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_start),
        .nib_valid (body_nib),
        .nib       (rxd),
        .octet_vld (octet_vld),
        .octet     (octet),
        .odd       (odd)
    );

    mii_crc32_acc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (frame_start),
        .en    (octet_vld),
        .data  (octet),
        .crc_q (crc_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oct_cnt_q  <= '0;
            sym_seen_q <= 1'b0;
            ovf_seen_q <= 1'b0;
        end else if (frame_start) begin
            oct_cnt_q  <= '0;
            sym_seen_q <= 1'b0;
            ovf_seen_q <= 1'b0;
        end else begin
            if (octet_vld && (oct_cnt_q < OCT_W'(OCT_LIMIT))) oct_cnt_q <= oct_cnt_q + 1'b1;
            if (body_nib && rx_er)    sym_seen_q <= 1'b1;
            if (body_nib && fifo_ovf) ovf_seen_q <= 1'b1;
        end
    end

    always_comb begin
        logic bad;
        ev_d = '0;
        bad  = (crc_q != CRC_GOOD);
        if (frame_end) begin
            ev_d.fcs      = bad && !odd;
            ev_d.align    = bad && odd;
            ev_d.symbol   = sym_seen_q;
            ev_d.too_long = (oct_cnt_q > OCT_W'(MAX_OCTETS));
            ev_d.missed   = ovf_seen_q;
            ev_d.errored  = bad || sym_seen_q || ovf_seen_q ||
                            (oct_cnt_q > OCT_W'(MAX_OCTETS));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign ev_errored    = ev_q.errored;
    assign ev_fcs_err    = ev_q.fcs;
    assign ev_align_err  = ev_q.align;
    assign ev_symbol_err = ev_q.symbol;
    assign ev_too_long   = ev_q.too_long;
    assign ev_missed     = ev_q.missed;

    // R2: pulses appear only right after a body ends
    a_r2_after_body: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q != '0) |-> ($past(state_q) == ST_BODY && !$past(rx_dv)));
    // R2: no pulse lasts two cycles
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_q != '0) |=> (ev_q == '0));
    // R4: parity makes the two CRC classes exclusive
    a_r4_fcs_align_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_fcs_err && ev_align_err));
    // R8: any specific class comes with the summary pulse
    a_r8_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fcs_err || ev_align_err || ev_symbol_err || ev_too_long || ev_missed) |-> ev_errored);
    // R9: a burst that ends in the preamble yields nothing
    a_r9_preamble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_PRE) |-> (ev_q == '0));
endmodule

// File: tb/mii_rx_err_classifier_tb.sv
module mii_rx_err_classifier_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_dv = 1'b0, rx_er = 1'b0, crs = 1'b0, fifo_ovf = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic ev_errored, ev_fcs_err, ev_align_err, ev_symbol_err, ev_too_long, ev_missed;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic [7:0] fb [0:1599];

    always #10 clk = ~clk;

    mii_rx_err_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs),
        .rxd(rxd), .fifo_ovf(fifo_ovf),
        .ev_errored(ev_errored), .ev_fcs_err(ev_fcs_err), .ev_align_err(ev_align_err),
        .ev_symbol_err(ev_symbol_err), .ev_too_long(ev_too_long), .ev_missed(ev_missed)
    );

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r = c ^ {24'd0, d};
        for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    task automatic run_frame(input int plen, input bit corrupt, input bit dribble,
                             input int er_at, input int ovf_at, input bit crs_on,
                             input bit pre_only);
        logic [31:0] c = 32'hFFFF_FFFF;
        int total = plen + 4;
        int nn;
        bit framed, bad, e_fcs, e_al, e_sym, e_long, e_ovf, e_any;
        for (int i = 0; i < plen; i++) begin
            fb[i] = 8'($urandom);
            c = crc_byte(c, fb[i]);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) fb[plen + i] = c[8*i +: 8];
        if (corrupt) fb[$urandom_range(0, total - 1)] ^= (8'h01 << $urandom_range(0, 7));
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < total; i++) c = crc_byte(c, fb[i]);
        nn     = total * 2 + (dribble ? 1 : 0);
        framed = crs_on && !pre_only;
        bad    = (c != 32'hDEBB20E3);
        e_fcs  = framed && bad && !dribble;
        e_al   = framed && bad && dribble;
        e_sym  = framed && (er_at >= 0) && (er_at < nn);
        e_ovf  = framed && (ovf_at >= 0) && (ovf_at < nn);
        e_long = framed && (total > 1518);
        e_any  = e_fcs || e_al || e_sym || e_ovf || e_long;

        for (int i = 0; i < 3; i++) begin
            rx_dv = 1'b1; crs = crs_on; rxd = 4'h5;
            @(negedge clk);
        end
        if (!pre_only) begin
            rxd = 4'hD;
            @(negedge clk);
            for (int k = 0; k < nn; k++) begin
                if (k < total * 2) rxd = k[0] ? fb[k/2][7:4] : fb[k/2][3:0];
                else               rxd = 4'($urandom);
                rx_er    = (k == er_at);
                fifo_ovf = (k == ovf_at);
                chk("R2 quiet in frame", ev_errored, 1'b0);
                @(negedge clk);
            end
        end
        rx_dv = 1'b0; crs = 1'b0; rx_er = 1'b0; fifo_ovf = 1'b0; rxd = 4'h0;
        @(negedge clk);
        if (!crs_on || pre_only) chk("R9 no event", ev_errored, 1'b0);
        else if (!e_any)         chk("R1 clean frame", ev_errored, 1'b0);
        chk("R3 fcs", ev_fcs_err, e_fcs);
        chk("R4 align", ev_align_err, e_al);
        chk("R5 symbol", ev_symbol_err, e_sym);
        chk("R6 too long", ev_too_long, e_long);
        chk("R7 missed", ev_missed, e_ovf);
        chk("R8 errored", ev_errored, e_any);
        @(negedge clk);
        chk("R2 single cycle", ev_errored | ev_fcs_err | ev_align_err | ev_symbol_err |
                               ev_too_long | ev_missed, 1'b0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
                summary();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset errored", ev_errored, 1'b0);
        chk("R2 reset fcs", ev_fcs_err, 1'b0);
        chk("R2 reset missed", ev_missed, 1'b0);

        run_frame(60, 0, 0, -1, -1, 1, 0);
        run_frame(60, 0, 1, -1, -1, 1, 0);
        run_frame(60, 1, 0, -1, -1, 1, 0);
        run_frame(60, 1, 1, -1, -1, 1, 0);
        run_frame(20, 0, 0, 0, -1, 1, 0);
        run_frame(20, 0, 0, 47, -1, 1, 0);
        run_frame(20, 0, 0, -1, 0, 1, 0);
        run_frame(20, 0, 0, -1, 47, 1, 0);
        run_frame(20, 0, 0, -1, -1, 0, 0);
        run_frame(20, 0, 0, 3, 5, 1, 1);
        run_frame(1514, 0, 0, -1, -1, 1, 0);
        run_frame(1515, 0, 0, -1, -1, 1, 0);

        for (int f = 0; f < 40; f++) begin
            int pl = $urandom_range(1, 80);
            int nn = (pl + 4) * 2;
            run_frame(pl, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                      ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, nn - 1)) : -1,
                      ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, nn - 1)) : -1,
                      1, 0);
        end
        summary();
    end
endmodule